// File: doc/BRIEF.md
# Successive Approximation Register Logic

This block is the digital core of a successive-approximation converter. At the start of each frame an active-low frame reset loads a trial code with only the most significant bit set. The trial code drives an external DAC, and a single comparator bit reports whether the held input lies above the DAC level. On each later conversion clock edge the block settles one bit, working from the most significant bit down. It keeps the tested bit when the comparator reads 1 and clears it when it reads 0. On the same edge it raises the next lower bit as the new trial.

A one-hot chain of stage flops marks the bit under test. The decision for a bit is stored on the edge where the chain moves on to the next stage. When the least significant stage moves on, an end-of-conversion flag rises. The code then holds the result until the next frame reset. With the default width of 8, a frame takes one reset period and eight decision periods, so it fits in a nine-period frame.

Top module: `sar_logic`

## Requirements
- R1: A clock edge with `rst_n` low loads `code` with only bit W-1 set (0x80 for W=8) and clears `eoc`, whatever the value of `comp`.
- R2: Each clock edge with `rst_n` high and `eoc` low settles the bit under test, starting at bit W-1 and moving down one bit per edge. The bit becomes 1 if `comp` is 1 and 0 if `comp` is 0. Bits settled earlier do not change.
- R3: The same edge sets the next lower bit to 1 as its trial. Bits below that trial bit stay 0.
- R4: `eoc` rises on the W-th clock edge with `rst_n` high after a reset edge, and not earlier.
- R5: Once `eoc` is high, `code` and `eoc` hold their values, whatever `comp` does, until the next edge with `rst_n` low.
- R6: With a comparator that reads 1 exactly when the held input is above the DAC level of `code`, the final `code` equals the input code. This includes all-zeros and all-ones inputs.
- R7: A reset edge during a conversion drops the partial result and starts a new conversion from the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low frame reset, sampled on the rising edge |
| comp | input | 1 | Comparator bit: 1 when the held input is above the DAC level |
| code | output | W | Trial code to the DAC; holds the result once `eoc` is high |
| eoc | output | 1 | End of conversion |

## Verification
A wrong stage position or a lost trial bit shows on `code` at the very next clock edge. The bench therefore compares the whole trial code against an expected prefix after every edge of every frame, and does not rely on the final value alone. If the chain stops advancing, or advances twice, `eoc` rises on the wrong edge, and the cycle-count assertion catches this. A decision stored into the wrong bit becomes a wrong final code, and the scoreboard reports it when that frame ends.

// File: rtl/sar_pkg.sv
package sar_pkg;
   // Code loaded by the frame reset: only the top bit set.
   function automatic logic [31:0] preset_code(input int unsigned w);
      return 32'(1) << (w - 1);
   endfunction
endpackage

// File: rtl/sar_stage_chain.sv
module sar_stage_chain #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] sel,
   output logic         done
);
   // sel is one-hot on the bit under test; all zero once done
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel  <= {1'b1, {(W-1){1'b0}}};
         done <= 1'b0;
      end else if (!done) begin
         sel  <= sel >> 1;
         done <= sel[0];
      end
   end
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         comp,
   input  logic [W-1:0] sel,
   output logic [W-1:0] code
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
         // top bit: preset to 1, never receives a trial from above
         always_ff @(posedge clk) begin
            if (!rst_n)      code[i] <= 1'b1;
            else if (sel[i]) code[i] <= comp;
         end
      end else begin : g_low
         always_ff @(posedge clk) begin
            if (!rst_n)          code[i] <= 1'b0;
            else if (sel[i])     code[i] <= comp;
            else if (sel[i + 1]) code[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sar_logic.sv
module sar_logic #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         comp,
   output logic [W-1:0] code,
   output logic         eoc
);
   localparam int unsigned STAGES = W;

   if (W < 2 || W > 32) begin : g_bad_width
      $error("sar_logic: W must be between 2 and 32");
   end

   logic [STAGES-1:0] sel;
   logic              done;

   sar_stage_chain #(.W(STAGES)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .done  (done)
   );

   sar_code_reg #(.W(W)) u_code (
      .clk   (clk),
      .rst_n (rst_n),
      .comp  (comp),
      .sel   (sel),
      .code  (code)
   );

   assign eoc = done;
endmodule

// File: rtl/sar_logic_chk.sv
module sar_logic_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] code,
   input logic [W-1:0] sel,
   input logic         eoc
);
   localparam int unsigned CW = $clog2(W + 2);
   localparam logic [W-1:0] PRESET = W'(sar_pkg::preset_code(W));

   logic          seen_rst = 1'b0;
   logic [CW-1:0] edges;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_rst <= 1'b1;
      if (!rst_n)                 edges <= '0;
      else if (edges < CW'(W))    edges <= edges + 1'b1;
   end

   // R1
   a_r1_preset: assert property (@(posedge clk) disable iff (!seen_rst)
      !rst_n |=> (code == PRESET) && !eoc);

   // R2 / R3: one bit settled and one trial raised per edge at most
   a_r2_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc |=> $countones(code ^ $past(code)) <= 2);

   a_r2_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel) && (eoc == (sel == '0)));

   // R4
   a_r4_eoc_timing: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
      eoc == (edges == CW'(W)));

   // R5
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> eoc && $stable(code));
endmodule

bind sar_logic sar_logic_chk #(.W(W)) u_sar_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .code  (code),
   .sel   (sel),
   .eoc   (eoc)
);

// File: tb/tb_sar_logic.sv
module tb_sar_logic;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         comp;
   logic [W-1:0] code;
   logic         eoc;
   logic [W-1:0] vin = '0;
   logic         ovr_en = 1'b0;
   logic         ovr_val = 1'b0;

   int errors = 0;
   int checks = 0;
   bit finished = 0;
   logic [W-1:0] expq[$];

   always #2 clk = ~clk;

   // ideal comparator: held input sits half an LSB above its code
   always_comb comp = ovr_en ? ovr_val : ((2 * int'(vin) + 1) > (2 * int'(code)));

   sar_logic #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .comp(comp), .code(code), .eoc(eoc)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected code after j decision edges
   function automatic logic [W-1:0] prefix(input logic [W-1:0] v, input int j);
      logic [W-1:0] r = '0;
      for (int b = W - 1; b >= W - j; b--) r[b] = v[b];
      if (j < W) r[W-1-j] = 1'b1;
      return r;
   endfunction

   // one frame; abort_at > 0 stops after that many decision edges
   task automatic run_frame(input logic [W-1:0] v, input int abort_at);
      @(negedge clk);
      vin = v;
      rst_n = 1'b0;
      ovr_en = 1'b1;
      ovr_val = v[0];          // any value: must be ignored during reset
      @(negedge clk);
      chk(code == 8'h80 && !eoc, "R1", {eoc, code}, 9'h080);
      if (abort_at == 0) expq.push_back(v);
      ovr_en = 1'b0;
      rst_n = 1'b1;
      for (int j = 1; j <= W; j++) begin
         @(negedge clk);
         chk(code == prefix(v, j), (j == W) ? "R6" : "R2/R3", code, prefix(v, j));
         chk(eoc == (j == W), "R4", eoc, (j == W));
         if (abort_at == j) return;
      end
      // R5: toggle comparator after end of conversion
      ovr_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         ovr_val = k[0];
         @(negedge clk);
         chk(code == v && eoc, "R5", {eoc, code}, {1'b1, v});
      end
      ovr_en = 1'b0;
   endtask

   // scoreboard monitor
   logic prev_eoc = 1'b0;
   always @(negedge clk) begin
      if (rst_n && eoc && !prev_eoc) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R6", code, 0);
         end else begin
            logic [W-1:0] e;
            e = expq.pop_front();
            chk(code == e, "R6", code, e);
         end
      end
      prev_eoc = eoc;
   end

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_up();
   end

   initial begin
      repeat (2) @(negedge clk);
      chk(code == 8'h80 && !eoc, "R1", {eoc, code}, 9'h080);
      run_frame(8'h00, 0);
      run_frame(8'hFF, 0);
      run_frame(8'h80, 0);
      run_frame(8'h7F, 0);
      run_frame(8'h55, 0);
      run_frame(8'hA6, 3);           // R7: aborted mid-conversion
      run_frame(8'h3C, 0);           // R7: clean restart
      for (int n = 0; n < 20; n++) run_frame(W'($urandom), 0);
      repeat (2) @(negedge clk);
      chk(expq.size() == 0, "R6", expq.size(), 0);
      finish_up();
   end
endmodule